// File: doc/BRIEF.md
# Monitor Channel Byte Receiver

This block is the device-side receive engine for a byte-wide monitor channel that rides inside a framed serial bus. A framing layer supplies a one-cycle strobe per frame; on that strobe the block looks at the downstream transmit-indicator bit (active low) and the downstream monitor byte. It drives back the upstream acknowledge bit (also active low) and an upstream monitor byte that stays all ones while it is receiving.

A byte is only accepted after the host has presented it unchanged in two frames in a row. The accepted byte goes to a command layer over a valid/ready pair. The block recognises a message end when the host leaves its indicator inactive for a programmable number of frames. It aborts when the host drops its indicator too early, when the command layer has not taken the previous byte, or when the command layer asks for an abort. An abort is shown to the host by keeping the acknowledge bit inactive until the host goes quiet.

Top module: `mcr_receiver`

## Requirements
- R1: After reset, mr_up_n is 1, rx_valid, msg_end and msg_abort are 0, and the block is idle.
- R2: State and outputs toward the host change only in the clock cycle after a cycle with frame_stb high. Changes on mx_dn_n and mon_dn while frame_stb is low have no effect.
- R3: In idle, a frame with mx_dn_n = 0 that follows a frame with mx_dn_n = 1 captures mon_dn as a candidate byte. mr_up_n stays 1 until a following active frame carries the same value. A different value replaces the candidate.
- R4: When a frame's byte matches the candidate, rx_valid rises with rx_data equal to that byte and mr_up_n becomes 0, both one clock after the strobe. mr_up_n stays 0 while mx_dn_n stays 0 and through a single frame with mx_dn_n = 1.
- R5: After an acknowledged byte and one frame with mx_dn_n = 1, a frame with mx_dn_n = 0 starts the next byte. mr_up_n returns to 1 and the new value becomes the candidate.
- R6: After an acknowledged byte, EOM_FRAMES (default 2) consecutive frames with mx_dn_n = 1 produce a one-cycle msg_end pulse and return mr_up_n to 1 and the block to idle. msg_end and msg_abort are never high together.
- R7: If mx_dn_n = 1 in a frame while a candidate awaits its match, msg_abort pulses for one cycle, mr_up_n stays 1, and no byte is delivered.
- R8: After any abort, mr_up_n stays 1 and frames with mx_dn_n = 0 start nothing. This lasts until EOM_FRAMES consecutive frames with mx_dn_n = 1 are seen, after which a new byte is accepted normally.
- R9: abort_req high in any cycle up to and including a strobe cycle causes an abort at that strobe. It takes priority over byte validation and over message end.
- R10: rx_valid stays high with rx_data unchanged until a cycle with rx_ready high. A byte that validates while an earlier byte is still untaken (rx_ready low in the strobe cycle) causes an abort instead of delivery. With rx_ready high in that same cycle, the new byte is delivered.
- R11: mon_up is 8'hFF at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_stb | input | 1 | One-cycle strobe: monitor bits of this frame are valid |
| mx_dn_n | input | 1 | Downstream transmit indicator, 0 = active |
| mon_dn | input | DW | Downstream monitor byte |
| mr_up_n | output | 1 | Upstream acknowledge, 0 = active |
| mon_up | output | DW | Upstream monitor byte, all ones |
| rx_valid | output | 1 | Validated byte available to the command layer |
| rx_data | output | DW | Validated byte |
| rx_ready | input | 1 | Command layer takes the byte |
| abort_req | input | 1 | Command layer requests an abort |
| msg_end | output | 1 | One-cycle pulse at end of message |
| msg_abort | output | 1 | One-cycle pulse when an abort is raised |

## Verification
Two pairs of events can fall on the same strobe. The first is an abort request landing on the frame whose byte would complete validation. The bench raises abort_req exactly in that strobe cycle and expects msg_abort with no rx_valid. It repeats the case on the second quiet frame of a message, where only msg_abort may pulse and msg_end must not. The second pair is the command layer taking a byte in the same cycle that the next byte validates: with rx_ready high only in that strobe cycle, the new byte must appear and no abort may occur, whereas with rx_ready low an abort must occur and the old byte must stay.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_ACK   = 2'd2,
        ST_ABORT = 2'd3
    } mcr_state_e;

    typedef struct packed {
        mcr_state_e st;
        logic       mr_n;
        logic       end_p;
        logic       abt_p;
        logic       pend;
    } mcr_ctl_t;

endpackage

// File: rtl/mcr_quiet_cnt.sv
module mcr_quiet_cnt #(
    parameter int LIMIT = 2,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    input  logic          mx_act,
    output logic [CW-1:0] cnt_now,
    output logic          quiet_now,
    output logic          prev_quiet
);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (mx_act)
            cnt_now = '0;
        else if (cnt_q >= LIM)
            cnt_now = LIM;
        else
            cnt_now = cnt_q + 1'b1;
        quiet_now  = (cnt_now >= LIM);
        prev_quiet = (cnt_q != '0);
        cnt_d      = stb ? cnt_now : cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= LIM;
        else
            cnt_q <= cnt_d;
    end

    a_r2_cnt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(cnt_q));

endmodule

// File: rtl/mcr_rx_hold.sv
module mcr_rx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          ready,
    output logic          valid,
    output logic [DW-1:0] data,
    output logic          blocked
);
    logic          valid_d, valid_q;
    logic [DW-1:0] data_d, data_q;

    always_comb begin
        valid_d = valid_q;
        data_d  = data_q;
        if (valid_q && ready)
            valid_d = 1'b0;
        if (load) begin
            valid_d = 1'b1;
            data_d  = load_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= valid_d;
            data_q  <= data_d;
        end
    end

    assign valid   = valid_q;
    assign data    = data_q;
    assign blocked = valid_q && !ready;

    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !ready) |=> (valid_q && $stable(data_q)));

endmodule

// File: rtl/mcr_receiver.sv
module mcr_receiver #(
    parameter int DW         = 8,
    parameter int EOM_FRAMES = 2,
    localparam int CW        = $clog2(EOM_FRAMES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_stb,
    input  logic          mx_dn_n,
    input  logic [DW-1:0] mon_dn,
    output logic          mr_up_n,
    output logic [DW-1:0] mon_up,
    output logic          rx_valid,
    output logic [DW-1:0] rx_data,
    input  logic          rx_ready,
    input  logic          abort_req,
    output logic          msg_end,
    output logic          msg_abort
);
    import mcr_pkg::*;

    mcr_ctl_t      ctl_d, ctl_q;
    logic [DW-1:0] cand_d, cand_q;
    logic          mx_act;
    logic [CW-1:0] quiet_cnt;
    logic          quiet_now, prev_quiet;
    logic          load, blocked;

    assign mx_act = !mx_dn_n;

    mcr_quiet_cnt #(.LIMIT(EOM_FRAMES)) u_quiet (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb        (frame_stb),
        .mx_act     (mx_act),
        .cnt_now    (quiet_cnt),
        .quiet_now  (quiet_now),
        .prev_quiet (prev_quiet)
    );

    mcr_rx_hold #(.DW(DW)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (mon_dn),
        .ready     (rx_ready),
        .valid     (rx_valid),
        .data      (rx_data),
        .blocked   (blocked)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.end_p = 1'b0;
        ctl_d.abt_p = 1'b0;
        ctl_d.pend  = ctl_q.pend | abort_req;
        cand_d      = cand_q;
        load        = 1'b0;
        if (frame_stb) begin
            ctl_d.pend = 1'b0;
            if (ctl_q.pend || abort_req) begin
                ctl_d.st    = ST_ABORT;
                ctl_d.mr_n  = 1'b1;
                ctl_d.abt_p = 1'b1;
            end else begin
                case (ctl_q.st)
                    ST_IDLE: begin
                        if (mx_act && prev_quiet) begin
                            ctl_d.st = ST_WAIT;
                            cand_d   = mon_dn;
                        end
                    end
                    ST_WAIT: begin
                        if (!mx_act || (mon_dn == cand_q && blocked)) begin
                            ctl_d.st    = ST_ABORT;
                            ctl_d.mr_n  = 1'b1;
                            ctl_d.abt_p = 1'b1;
                        end else if (mon_dn == cand_q) begin
                            load       = 1'b1;
                            ctl_d.st   = ST_ACK;
                            ctl_d.mr_n = 1'b0;
                        end else begin
                            cand_d = mon_dn;
                        end
                    end
                    ST_ACK: begin
                        if (mx_act && prev_quiet) begin
                            ctl_d.st   = ST_WAIT;
                            ctl_d.mr_n = 1'b1;
                            cand_d     = mon_dn;
                        end else if (quiet_now) begin
                            ctl_d.st    = ST_IDLE;
                            ctl_d.mr_n  = 1'b1;
                            ctl_d.end_p = 1'b1;
                        end
                    end
                    default: begin
                        if (quiet_now)
                            ctl_d.st = ST_IDLE;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '{st: ST_IDLE, mr_n: 1'b1, end_p: 1'b0, abt_p: 1'b0, pend: 1'b0};
            cand_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            cand_q <= cand_d;
        end
    end

    assign mr_up_n   = ctl_q.mr_n;
    assign mon_up    = '1;
    assign msg_end   = ctl_q.end_p;
    assign msg_abort = ctl_q.abt_p;

    a_r2_mr_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_stb) |-> $stable(mr_up_n));

    a_r3_no_ack_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_WAIT) |-> mr_up_n);

    a_r4_ack_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> !mr_up_n);

    a_r6_end_abort_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(msg_end && msg_abort));

    a_r7_abort_mr_idle: assert property (@(posedge clk) disable iff (!rst_n)
        msg_abort |-> mr_up_n);

    a_r9_req_served: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && (ctl_q.pend || abort_req)) |=> (msg_abort && !msg_end));

    a_r8_abort_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_ABORT) |-> (mr_up_n && !$rose(rx_valid)));

endmodule

// File: tb/mcr_receiver_tb.sv
`timescale 1ns/1ps
module mcr_receiver_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_stb = 1'b0;
    logic       mx_dn_n = 1'b1;
    logic [7:0] mon_dn = 8'hFF;
    logic       mr_up_n;
    logic [7:0] mon_up;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_ready = 1'b1;
    logic       abort_req = 1'b0;
    logic       msg_end;
    logic       msg_abort;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic ready_def = 1'b1;

    always #4 clk = ~clk;

    mcr_receiver u_dut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .mx_dn_n(mx_dn_n),
        .mon_dn(mon_dn), .mr_up_n(mr_up_n), .mon_up(mon_up),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .abort_req(abort_req), .msg_end(msg_end), .msg_abort(msg_abort)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // One frame: strobe for one clock, sample at the following falling edge.
    task automatic frame(input logic mx_n, input logic [7:0] d, input logic abt, input logic rdy);
        mx_dn_n   = mx_n;
        mon_dn    = d;
        abort_req = abt;
        rx_ready  = rdy;
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
        abort_req = 1'b0;
        rx_ready  = ready_def;
    endtask

    task automatic fr(input logic mx_n, input logic [7:0] d);
        frame(mx_n, d, 1'b0, ready_def);
    endtask

    // Line noise between strobes must not move anything (R2).
    task automatic noise();
        logic mr0;
        mr0 = mr_up_n;
        for (int k = 0; k < 2; k++) begin
            mx_dn_n = 1'($urandom);
            mon_dn  = 8'($urandom);
            @(negedge clk);
            chk("R2 mr stable between frames", mr_up_n, mr0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 mr after reset", mr_up_n, 1);
        chk("R1 valid after reset", rx_valid, 0);
        chk("R1 end after reset", msg_end, 0);
        chk("R1 abort after reset", msg_abort, 0);
        chk("R11 mon_up", mon_up, 8'hFF);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep every byte value through a one-byte message.
        for (int v = 0; v < 256; v++) begin
            fr(1'b0, 8'(v));
            chk("R3 no ack on first frame", mr_up_n, 1);
            chk("R3 no byte on first frame", rx_valid, 0);
            noise();
            fr(1'b0, 8'(v));
            chk("R4 ack", mr_up_n, 0);
            chk("R4 valid", rx_valid, 1);
            chk("R4 data", rx_data, 32'(v));
            chk("R11 mon_up while receiving", mon_up, 8'hFF);
            fr(1'b1, 8'hFF);
            chk("R4 ack kept over one quiet frame", mr_up_n, 0);
            chk("R6 no early end", msg_end, 0);
            noise();
            fr(1'b1, 8'hFF);
            chk("R6 end pulse", msg_end, 1);
            chk("R6 mr released", mr_up_n, 1);
            @(negedge clk);
            chk("R6 end is one cycle", msg_end, 0);
        end

        // Mismatch replaces the candidate, then a second byte in the message.
        for (int i = 0; i < 16; i++) begin
            logic [7:0] a, b;
            a = 8'(i * 17);
            b = a ^ 8'h5A;
            fr(1'b0, a);
            fr(1'b0, b);
            chk("R3 mismatch no ack", mr_up_n, 1);
            chk("R3 mismatch no byte", rx_valid, 0);
            fr(1'b0, b);
            chk("R3 replaced candidate accepted", rx_data, 32'(b));
            chk("R4 ack after match", mr_up_n, 0);
            fr(1'b0, b);
            chk("R4 ack held while mx active", mr_up_n, 0);
            fr(1'b1, 8'hFF);
            fr(1'b0, a);
            chk("R5 next byte drops ack", mr_up_n, 1);
            chk("R5 next byte not yet valid", rx_valid, 0);
            fr(1'b0, a);
            chk("R5 second byte data", rx_data, 32'(a));
            chk("R5 second byte valid", rx_valid, 1);
            fr(1'b1, 8'hFF);
            fr(1'b1, 8'hFF);
            chk("R6 end after two bytes", msg_end, 1);
        end

        // Early release while waiting for a match.
        fr(1'b0, 8'h3C);
        fr(1'b1, 8'hFF);
        chk("R7 abort pulse", msg_abort, 1);
        chk("R7 mr inactive", mr_up_n, 1);
        chk("R7 no byte", rx_valid, 0);
        fr(1'b1, 8'hFF);
        chk("R8 back to idle no pulse", msg_abort, 0);
        fr(1'b0, 8'h44);
        fr(1'b0, 8'h44);
        chk("R8 accepted after quiet", rx_data, 32'h44);
        fr(1'b1, 8'hFF);
        fr(1'b1, 8'hFF);

        // Abort request between strobes, then host activity ignored.
        fr(1'b0, 8'h81);
        fr(1'b0, 8'h81);
        abort_req = 1'b1;
        @(negedge clk);
        abort_req = 1'b0;
        chk("R2 request waits for frame", msg_abort, 0);
        fr(1'b0, 8'h81);
        chk("R9 pending request aborts", msg_abort, 1);
        chk("R9 mr inactive", mr_up_n, 1);
        fr(1'b1, 8'hFF);
        fr(1'b0, 8'hC3);
        chk("R8 start ignored in abort", mr_up_n, 1);
        fr(1'b0, 8'hC3);
        chk("R8 no ack in abort", mr_up_n, 1);
        chk("R8 no byte in abort", rx_valid, 0);
        fr(1'b1, 8'hFF);
        fr(1'b1, 8'hFF);
        fr(1'b0, 8'h5D);
        fr(1'b0, 8'h5D);
        chk("R8 recovered", rx_data, 32'h5D);
        chk("R8 recovered ack", mr_up_n, 0);
        fr(1'b1, 8'hFF);
        fr(1'b1, 8'hFF);

        // Abort request on the validating frame.
        fr(1'b0, 8'hE7);
        frame(1'b0, 8'hE7, 1'b1, 1'b1);
        chk("R9 abort beats validation", msg_abort, 1);
        chk("R9 no byte", rx_valid, 0);
        chk("R9 mr inactive", mr_up_n, 1);
        fr(1'b1, 8'hFF);
        fr(1'b1, 8'hFF);

        // Abort request on the ending frame.
        fr(1'b0, 8'h12);
        fr(1'b0, 8'h12);
        fr(1'b1, 8'hFF);
        frame(1'b1, 8'hFF, 1'b1, 1'b1);
        chk("R9 abort beats end", msg_abort, 1);
        chk("R9 no end pulse", msg_end, 0);
        fr(1'b1, 8'hFF);

        // Consumer stalls: byte held, next byte aborts.
        ready_def = 1'b0;
        rx_ready  = 1'b0;
        fr(1'b0, 8'hA5);
        fr(1'b0, 8'hA5);
        fr(1'b1, 8'hFF);
        chk("R10 held valid", rx_valid, 1);
        chk("R10 held data", rx_data, 32'hA5);
        fr(1'b0, 8'h6B);
        fr(1'b0, 8'h6B);
        chk("R10 overflow aborts", msg_abort, 1);
        chk("R10 old byte kept", rx_data, 32'hA5);
        chk("R10 old byte valid", rx_valid, 1);
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
        chk("R10 taken", rx_valid, 0);
        fr(1'b1, 8'hFF);
        fr(1'b1, 8'hFF);

        // Consumer takes the old byte in the validating cycle.
        fr(1'b0, 8'h90);
        fr(1'b0, 8'h90);
        fr(1'b1, 8'hFF);
        fr(1'b0, 8'h09);
        frame(1'b0, 8'h09, 1'b0, 1'b1);
        chk("R10 same-cycle take no abort", msg_abort, 0);
        chk("R10 same-cycle new valid", rx_valid, 1);
        chk("R10 same-cycle new data", rx_data, 32'h09);
        ready_def = 1'b1;
        rx_ready  = 1'b1;
        @(negedge clk);
        fr(1'b1, 8'hFF);
        fr(1'b1, 8'hFF);
        chk("R6 end after handoff test", msg_end, 1);
        chk("R11 mon_up at end", mon_up, 8'hFF);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule